// File: doc/BRIEF.md
# USB Interrupt-IN Endpoint Transmitter

This block is the transmit side of a single USB device interrupt-IN endpoint. Software loads packet bytes into an 8-entry byte store through a valid/ready byte stream. It controls and observes the endpoint through one 32-bit control/status word. A protocol engine presents IN tokens and host handshake events. The block answers every token with a DATA, NAK or STALL response code one cycle later. After a DATA code it streams the packet bytes back to the engine over a second valid/ready stream.

A packet becomes ready for transmission in one of two ways: the store fills to 8 bytes, or software sets the short-packet bit. The short-packet bit arms a short or zero-length packet. The bytes are held after transmission until the host acknowledges them. A host timeout leaves the packet armed, so the next token sends it again. Status flags are set by the protocol events: packet complete, underrun and sent-stall. Software clears each of them by writing 1. The interrupt request is raised when packet complete or sent-stall is set and the endpoint mask bit is 0.

Both byte streams use ordinary valid/ready rules. A byte moves on a clock edge where valid and ready are both high. The ready output of the load stream does not depend on the load-valid input. The ready output is low while a packet is armed or being transmitted. On the transmit stream the block holds tx_valid, tx_data and tx_last steady until the engine takes the byte. A host timeout or a flush may withdraw tx_valid early.

Top module: `usb_in_ep_tx`

## Requirements
- R1: After reset, csr_rdata reads 0x00000001 and irq is 0. wr_ready is 1. The interrupt mask reads as set, so writing 1 to packet complete never raises irq until the mask is written to 0.
- R2: A byte is stored on each edge where wr_valid and wr_ready are both 1. wr_ready is 0 in three cases: 8 bytes are stored, the short-packet bit is set, or a packet is being transmitted or awaits its handshake.
- R3: Each IN token (tok_in high for one cycle) accepted while no packet is in flight gives resp_valid on the next cycle. The code is NAK (2'd2) when no packet is armed, and this includes a partly filled store.
- R4: With 8 bytes stored and force-stall clear, a token gives DATA (2'd1) with resp_len 8. The bytes then stream out in write order, and tx_last is 1 only on the eighth byte.
- R5: Writing 1 to control bit 7 arms a packet of the stored byte count. The count may be 0, which gives DATA with resp_len 0 and no bytes. Bit 7 reads 1 while the packet is armed, and writing 0 to it has no effect.
- R6: A host_ack after all bytes are delivered does four things: it sets bit 1 (packet complete), clears bit 7, empties the store and sets bit 0. Writing 1 to bit 1 clears the flag.
- R7: A host_timeout after delivery keeps the packet, so the next token resends the same length and bytes. Bit 1 stays 0.
- R8: A host_timeout while bytes remain undelivered sets bit 3 (underrun). The packet is kept and resent from its first byte. Writing 1 to bit 3 clears the flag.
- R9: Bit 5 (force-stall) is read/write. While it is 1, every token is answered with STALL (2'd3), even when a packet is armed. Each such token sets bit 4 (sent-stall), and writing 1 to bit 4 clears it.
- R10: Writing 1 to bit 2 empties the store and clears bit 7, so bit 0 reads 1. Bit 2 always reads 0.
- R11: irq is 1 exactly when (bit 1 or bit 4) is 1 and the mask is 0.
- R12: Bit 6 and bits 31:8 read 0 even after writes of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Load stream: byte offered |
| wr_data | input | 8 | Load stream: byte value |
| wr_ready | output | 1 | Load stream: byte store accepts |
| csr_wr | input | 1 | Write strobe for the control/status word |
| csr_wdata | input | 8 | Control/status write data (low byte) |
| csr_rdata | output | 32 | Control/status read value |
| mask_wr | input | 1 | Write strobe for the interrupt mask |
| mask_wdata | input | 1 | New mask value (1 = masked) |
| irq | output | 1 | Interrupt request |
| tok_in | input | 1 | IN token pulse from the protocol engine |
| host_ack | input | 1 | Host acknowledged the DATA packet |
| host_timeout | input | 1 | Host handshake timed out |
| resp_valid | output | 1 | Response code valid (one cycle) |
| resp_code | output | 2 | 1 DATA, 2 NAK, 3 STALL |
| resp_len | output | 4 | Byte count of a DATA response |
| tx_valid | output | 1 | Transmit stream: byte offered |
| tx_data | output | 8 | Transmit stream: byte value |
| tx_last | output | 1 | Transmit stream: final byte of packet |
| tx_ready | input | 1 | Transmit stream: engine accepts |

## Verification
The checker relies on a well-behaved protocol engine. It presents tokens only while no packet is in flight. It gives host_ack only once the last byte has been delivered. It never raises host_ack and host_timeout together. The bench obeys these rules in each scenario task. Every token waits for the previous packet to reach its handshake. Every ack follows a complete stream, and timeouts are issued alone, either mid-stream for the underrun case or after delivery for the resend case.

// File: rtl/usb_tx_pkg.sv
package usb_tx_pkg;
  typedef enum logic [1:0] {
    HS_NONE  = 2'd0,
    HS_DATA  = 2'd1,
    HS_NAK   = 2'd2,
    HS_STALL = 2'd3
  } hs_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2
  } seq_e;

  localparam int B_ROOM  = 0;
  localparam int B_DONE  = 1;
  localparam int B_FLUSH = 2;
  localparam int B_UNDER = 3;
  localparam int B_SSENT = 4;
  localparam int B_FSTL  = 5;
  localparam int B_SHORT = 7;
endpackage

// File: rtl/ep_tx_fifo.sv
module ep_tx_fifo #(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  input  logic          rewind,
  input  logic          clear,
  output logic [CW-1:0] count,
  output logic [DW-1:0] head
);
  logic [DW-1:0] mem [DEPTH];
  logic [IW-1:0] rd_idx;

  always_ff @(posedge clk) begin
    if (push) mem[count[IW-1:0]] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '0;
      rd_idx <= '0;
    end else if (clear) begin
      count  <= '0;
      rd_idx <= '0;
    end else begin
      if (push) count <= count + CW'(1);
      if (rewind)   rd_idx <= '0;
      else if (pop) rd_idx <= rd_idx + IW'(1);
    end
  end

  assign head = mem[rd_idx];
endmodule

// File: rtl/ep_tx_seq.sv
module ep_tx_seq
  import usb_tx_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tok_in,
  input  logic          host_ack,
  input  logic          host_timeout,
  input  logic          flush,
  input  logic          force_stall,
  input  logic          armed,
  input  logic [CW-1:0] count,
  input  logic          tx_ready,
  output logic          resp_valid,
  output logic [1:0]    resp_code,
  output logic [CW-1:0] resp_len,
  output logic          tx_valid,
  output logic          tx_last,
  output logic          pop,
  output logic          rewind,
  output logic          ack_done,
  output logic          ev_sst,
  output logic          ev_tur,
  output logic          busy
);
  seq_e          state;
  logic [CW-1:0] sent_cnt;
  logic          tok_take;
  hs_e           pick;

  always_comb begin
    tok_take = tok_in && (state == ST_IDLE) && !flush;
    if (force_stall)  pick = HS_STALL;
    else if (armed)   pick = HS_DATA;
    else              pick = HS_NAK;
  end

  assign tx_valid = (state == ST_SEND);
  assign tx_last  = tx_valid && (sent_cnt == count - CW'(1));
  assign pop      = tx_valid && tx_ready;
  assign busy     = (state != ST_IDLE);
  assign rewind   = busy && host_timeout && !flush;
  assign ack_done = (state == ST_WAIT) && host_ack && !host_timeout && !flush;
  assign ev_tur   = tx_valid && host_timeout && !flush;
  assign ev_sst   = tok_take && (pick == HS_STALL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_code  <= HS_NONE;
      resp_len   <= '0;
    end else begin
      resp_valid <= tok_take;
      if (tok_take) begin
        resp_code <= pick;
        resp_len  <= (pick == HS_DATA) ? count : '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      sent_cnt <= '0;
    end else if (flush) begin
      state    <= ST_IDLE;
      sent_cnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          sent_cnt <= '0;
          if (tok_take && pick == HS_DATA)
            state <= (count == '0) ? ST_WAIT : ST_SEND;
        end
        ST_SEND: begin
          if (host_timeout) begin
            state    <= ST_IDLE;
            sent_cnt <= '0;
          end else if (pop) begin
            sent_cnt <= sent_cnt + CW'(1);
            if (tx_last) state <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (host_timeout || host_ack) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ep_tx_csr.sv
module ep_tx_csr
  import usb_tx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        csr_wr,
  input  logic [7:0]  csr_wdata,
  input  logic        mask_wr,
  input  logic        mask_wdata,
  input  logic        ev_done,
  input  logic        ev_sst,
  input  logic        ev_tur,
  input  logic        room,
  output logic [31:0] csr_rdata,
  output logic        short_arm,
  output logic        force_stall,
  output logic        flush,
  output logic        irq_mask,
  output logic        irq
);
  logic done_q, sst_q, tur_q;
  logic w1;

  assign w1    = csr_wr;
  assign flush = w1 && csr_wdata[B_FLUSH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q      <= 1'b0;
      sst_q       <= 1'b0;
      tur_q       <= 1'b0;
      short_arm   <= 1'b0;
      force_stall <= 1'b0;
      irq_mask    <= 1'b1;
    end else begin
      if (ev_done)                        done_q <= 1'b1;
      else if (w1 && csr_wdata[B_DONE])   done_q <= 1'b0;

      if (ev_sst)                         sst_q <= 1'b1;
      else if (w1 && csr_wdata[B_SSENT])  sst_q <= 1'b0;

      if (ev_tur)                         tur_q <= 1'b1;
      else if (w1 && csr_wdata[B_UNDER])  tur_q <= 1'b0;

      if (w1 && csr_wdata[B_SHORT])       short_arm <= 1'b1;
      else if (ev_done || flush)          short_arm <= 1'b0;

      if (w1) force_stall <= csr_wdata[B_FSTL];
      if (mask_wr) irq_mask <= mask_wdata;
    end
  end

  always_comb begin
    csr_rdata          = '0;
    csr_rdata[B_ROOM]  = room;
    csr_rdata[B_DONE]  = done_q;
    csr_rdata[B_UNDER] = tur_q;
    csr_rdata[B_SSENT] = sst_q;
    csr_rdata[B_FSTL]  = force_stall;
    csr_rdata[B_SHORT] = short_arm;
  end

  assign irq = (done_q || sst_q) && !irq_mask;
endmodule

// File: rtl/usb_in_ep_tx.sv
module usb_in_ep_tx
  import usb_tx_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  output logic          wr_ready,
  input  logic          csr_wr,
  input  logic [7:0]    csr_wdata,
  output logic [31:0]   csr_rdata,
  input  logic          mask_wr,
  input  logic          mask_wdata,
  output logic          irq,
  input  logic          tok_in,
  input  logic          host_ack,
  input  logic          host_timeout,
  output logic          resp_valid,
  output logic [1:0]    resp_code,
  output logic [CW-1:0] resp_len,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data,
  output logic          tx_last,
  input  logic          tx_ready
);
  logic [CW-1:0] count;
  logic short_arm, force_stall, flush, irq_mask;
  logic armed, busy, pop, rewind, ack_done, ev_sst, ev_tur, room;

  assign armed    = short_arm || (count == CW'(DEPTH));
  assign wr_ready = !armed && !busy;
  assign room     = (count == '0) && !busy;

  ep_tx_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(wr_valid && wr_ready), .push_data(wr_data),
    .pop(pop), .rewind(rewind), .clear(flush || ack_done),
    .count(count), .head(tx_data)
  );

  ep_tx_seq #(.DEPTH(DEPTH)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .tok_in(tok_in), .host_ack(host_ack), .host_timeout(host_timeout),
    .flush(flush), .force_stall(force_stall), .armed(armed),
    .count(count), .tx_ready(tx_ready),
    .resp_valid(resp_valid), .resp_code(resp_code), .resp_len(resp_len),
    .tx_valid(tx_valid), .tx_last(tx_last), .pop(pop), .rewind(rewind),
    .ack_done(ack_done), .ev_sst(ev_sst), .ev_tur(ev_tur), .busy(busy)
  );

  ep_tx_csr u_csr (
    .clk(clk), .rst_n(rst_n),
    .csr_wr(csr_wr), .csr_wdata(csr_wdata),
    .mask_wr(mask_wr), .mask_wdata(mask_wdata),
    .ev_done(ack_done), .ev_sst(ev_sst), .ev_tur(ev_tur), .room(room),
    .csr_rdata(csr_rdata), .short_arm(short_arm), .force_stall(force_stall),
    .flush(flush), .irq_mask(irq_mask), .irq(irq)
  );
endmodule

// File: rtl/usb_in_ep_tx_chk.sv
module usb_in_ep_tx_chk #(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tok_in,
  input logic          busy,
  input logic          flush,
  input logic          force_stall,
  input logic          irq_mask,
  input logic          irq,
  input logic          wr_ready,
  input logic          host_timeout,
  input logic          resp_valid,
  input logic [1:0]    resp_code,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [DW-1:0] tx_data,
  input logic [CW-1:0] count,
  input logic [31:0]   csr_rdata
);
  p_answer_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_in && !busy && !flush) |=> resp_valid);

  p_stall_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_in && !busy && !flush && force_stall) |=> (resp_code == 2'd3));

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  p_no_load_in_flight_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !wr_ready);

  p_tx_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !host_timeout && !flush) |=> (tx_valid && $stable(tx_data)));

  p_flush_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0));

  p_masked_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_mask |-> !irq);

  p_reserved_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_rdata[31:8] == 24'd0) && !csr_rdata[6] && !csr_rdata[2]);
endmodule

bind usb_in_ep_tx usb_in_ep_tx_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tok_in(tok_in), .busy(busy), .flush(flush),
  .force_stall(force_stall), .irq_mask(irq_mask), .irq(irq),
  .wr_ready(wr_ready), .host_timeout(host_timeout),
  .resp_valid(resp_valid), .resp_code(resp_code), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .tx_data(tx_data), .count(count), .csr_rdata(csr_rdata)
);

// File: tb/usb_in_ep_tx_bench.sv
`timescale 1ns/1ps
module usb_in_ep_tx_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 0, csr_wr = 0, mask_wr = 0, mask_wdata = 0;
  logic tok_in = 0, host_ack = 0, host_timeout = 0, tx_ready = 0;
  logic [7:0] wr_data = 0, csr_wdata = 0;
  logic wr_ready, irq, resp_valid, tx_valid, tx_last;
  logic [31:0] csr_rdata;
  logic [1:0] resp_code;
  logic [3:0] resp_len;
  logic [7:0] tx_data;
  int vectors = 0, errors = 0;
  logic [7:0] pkt [8];

  always #2.5 clk = ~clk;

  usb_in_ep_tx u_usb_in_ep_tx (.*);

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load(int n, int seed);
    for (int i = 0; i < n; i++) begin
      pkt[i] = 8'(seed + 17 * i);
      wr_valid = 1; wr_data = pkt[i]; tick();
    end
    wr_valid = 0;
  endtask

  task automatic csr(logic [7:0] v); csr_wr = 1; csr_wdata = v; tick(); csr_wr = 0; endtask

  task automatic token(string req, logic [1:0] code, int len);
    tok_in = 1; tick(); tok_in = 0;
    chk(req, {31'd0, resp_valid}, 1);
    chk(req, {30'd0, resp_code}, {30'd0, code});
    if (code == 2'd1) chk(req, {28'd0, resp_len}, len);
  endtask

  task automatic drain(string req, int len);
    tx_ready = 1;
    for (int i = 0; i < len; i++) begin
      chk(req, {23'd0, tx_valid, tx_data}, {23'd0, 1'b1, pkt[i]});
      chk(req, {31'd0, tx_last}, (i == len - 1) ? 1 : 0);
      tick();
    end
    tx_ready = 0;
    chk(req, {31'd0, tx_valid}, 0);
  endtask

  task automatic ack(); host_ack = 1; tick(); host_ack = 0; endtask
  task automatic tmo(); host_timeout = 1; tick(); host_timeout = 0; endtask

  task automatic t_reset();
    chk("R1", csr_rdata, 32'h1);
    chk("R1", {31'd0, irq}, 0);
    chk("R1", {31'd0, wr_ready}, 1);
    token("R3", 2'd2, 0);
  endtask

  task automatic t_full();
    load(8, 8'h10);
    chk("R2", {31'd0, wr_ready}, 0);
    token("R4", 2'd1, 8);
    drain("R4", 8);
    ack();
    chk("R6", csr_rdata, 32'h3);
    chk("R1", {31'd0, irq}, 0);
    mask_wr = 1; mask_wdata = 0; tick(); mask_wr = 0;
    chk("R11", {31'd0, irq}, 1);
    csr(8'h02);
    chk("R6", csr_rdata, 32'h1);
    chk("R11", {31'd0, irq}, 0);
  endtask

  task automatic t_short();
    load(3, 8'h40);
    token("R3", 2'd2, 0);
    csr(8'h00);
    chk("R5", csr_rdata, 32'h0);
    csr(8'h80);
    chk("R5", csr_rdata, 32'h80);
    chk("R2", {31'd0, wr_ready}, 0);
    csr(8'h00);
    chk("R5", csr_rdata, 32'h80);
    token("R5", 2'd1, 3);
    drain("R5", 3);
    ack();
    chk("R6", csr_rdata, 32'h3);
    csr(8'h02);
    csr(8'h80);
    token("R5", 2'd1, 0);
    chk("R5", {31'd0, tx_valid}, 0);
    ack();
    chk("R5", csr_rdata, 32'h3);
    csr(8'h02);
  endtask

  task automatic t_resend();
    load(5, 8'h70);
    csr(8'h80);
    token("R7", 2'd1, 5);
    drain("R7", 5);
    tmo();
    chk("R7", csr_rdata, 32'h80);
    token("R7", 2'd1, 5);
    drain("R7", 5);
    ack();
    chk("R7", csr_rdata, 32'h3);
    csr(8'h02);
  endtask

  task automatic t_underrun();
    load(4, 8'hA0);
    csr(8'h80);
    token("R8", 2'd1, 4);
    tx_ready = 1; tick(); tx_ready = 0;
    tmo();
    chk("R8", csr_rdata, 32'h88);
    token("R8", 2'd1, 4);
    drain("R8", 4);
    ack();
    csr(8'h0A);
    chk("R8", csr_rdata, 32'h1);
  endtask

  task automatic t_stall();
    load(8, 8'h22);
    csr(8'h20);
    chk("R9", csr_rdata, 32'h20);
    token("R9", 2'd3, 0);
    chk("R9", csr_rdata, 32'h30);
    chk("R11", {31'd0, irq}, 1);
    token("R9", 2'd3, 0);
    csr(8'h10);
    chk("R9", csr_rdata, 32'h0);
    chk("R11", {31'd0, irq}, 0);
    token("R9", 2'd1, 8);
    drain("R9", 8);
    ack();
    csr(8'h02);
  endtask

  task automatic t_flush();
    load(6, 8'h05);
    csr(8'h80);
    csr(8'h04);
    chk("R10", csr_rdata, 32'h1);
    chk("R10", {31'd0, wr_ready}, 1);
    token("R10", 2'd2, 0);
    csr(8'h4D);
    chk("R12", csr_rdata, 32'h1);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1; tick();
    t_reset();
    t_full();
    t_short();
    t_resend();
    t_underrun();
    t_stall();
    t_flush();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule